// File: doc/BRIEF.md
# Interrupt Control and Flag Register

This block is the interrupt control register of a small microcontroller core, together with the logic that captures interrupt events. It latches three core event sources: a timer rollover, a rising edge on an external interrupt pin, and a level change on any of six port pins. It holds an enable bit for each source, a peripheral-group enable and a global enable. From these it forms a single interrupt request to the CPU. Software reads and writes all eight bits through a simple register port. The CPU, vectoring, context save and the timer are outside the block.

A flag records its event whether or not any enable is set. Software must clear a flag itself by writing 0 to it. The external pin and the port pins are asynchronous, so each passes through a two-stage synchronizer before any logic uses it. Port-change detection compares the synchronized pins with a reference that is captured each time software reads the port. A per-pin mask chooses which pins take part in the comparison.

Top module: `irq_ctrl_reg`

## Requirements
- R1: While reset is asserted and right after it, all eight register bits read 0 and `irqOut` is 0.
- R2: Bit positions from 7 down to 0 are: global enable, peripheral enable, timer enable, external enable, port-change enable, timer flag, external flag, port-change flag. A write with `regWrEn` stores `regWrData` into all eight bits, and the new value is visible on `regRdData` after that clock edge.
- R3: A `timerRoll` pulse sampled at a clock edge sets the timer flag (bit 2) at that edge, whatever the enables hold.
- R4: A rising edge of `extPin` sets the external flag (bit 1) at the third clock edge after the pin changes: two synchronizer stages, then the edge detector. A pin held high does not set the flag again, and a falling edge never sets it.
- R5: The port-change flag (bit 0) is set when a synchronized pin differs from its reference value and that pin's bit in `portChgMask` is 1. A pin whose mask bit is 0 has no effect.
- R6: A `portRdStrobe` loads the synchronized pins (also driven on `portRdData`) into the reference. Until that happens, a remaining mismatch sets the port-change flag again on every cycle, even after software has written it to 0.
- R7: Hardware never clears a flag. A flag stays 1 until a register write puts 0 in its bit.
- R8: When a hardware set and a software write of 0 reach the same flag in the same cycle, the flag ends up 1.
- R9: `irqOut` = GIE and ((timer enable and flag) or (external enable and flag) or (port enable and flag) or (peripheral enable and `periphReq`)).
- R10: With the global enable at 0, `irqOut` stays 0. With the peripheral enable at 0, `periphReq` has no effect on `irqOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Current register contents |
| timerRoll | input | 1 | One-cycle pulse when the timer wraps from its maximum count to zero |
| extPin | input | 1 | Asynchronous external interrupt pin |
| periphReq | input | 1 | Combined peripheral-group interrupt request |
| portPins | input | 6 | Asynchronous port pins |
| portChgMask | input | 6 | Per-pin enable for change detection |
| portRdStrobe | input | 1 | Port read strobe; captures the reference |
| portRdData | output | 6 | Synchronized port pin values |
| irqOut | output | 1 | Interrupt request to the CPU |

## Verification
On every cycle, the assertions check the reset value, write storage of the enable bits, the setting of the timer flag, hardware priority over a clearing write, flag stickiness when no write occurs, global masking and the request for an enabled timer flag. The bench scenarios are needed to show the synchronizer latency of the external pin, the single trigger on a held level, mask filtering of the port pins, the repeated setting of the port-change flag until a port read, and the peripheral-group gating of the request.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int REG_W    = 8;
  localparam int BIT_GIE  = 7;
  localparam int BIT_PEIE = 6;
  localparam int BIT_TIE  = 5;
  localparam int BIT_XIE  = 4;
  localparam int BIT_PIE  = 3;
  localparam int BIT_TF   = 2;
  localparam int BIT_XF   = 1;
  localparam int BIT_PF   = 0;

  typedef struct packed {
    logic wrEn;
    logic timerSet;
    logic extSet;
    logic portSet;
  } ctlStrobe_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= '0;
        else       stage[g] <= asyncIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= '0;
        else       stage[g] <= stage[g-1];
      end
    end
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/irq_ctrl_ctl.sv
module irq_ctrl_ctl
  import irq_ctrl_pkg::*;
#(
  parameter int PINS        = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            regWrEn,
  input  logic            timerRoll,
  input  logic            extPin,
  input  logic [PINS-1:0] portPins,
  input  logic [PINS-1:0] portChgMask,
  input  logic            portRdStrobe,
  output logic [PINS-1:0] pinSync,
  output ctlStrobe_t      strobe
);
  logic            extSync;
  logic            extPrev;
  logic            extRise;
  logic [PINS-1:0] refLatch;
  logic [PINS-1:0] pinDiff;

  irq_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) extSync_i (
    .clk(clk), .rstN(rstN), .asyncIn(extPin), .syncOut(extSync)
  );

  irq_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) pinSync_i (
    .clk(clk), .rstN(rstN), .asyncIn(portPins), .syncOut(pinSync)
  );

  // Edge detector after the synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) extPrev <= 1'b0;
    else       extPrev <= extSync;
  end
  assign extRise = extSync & ~extPrev;

  // Reference captured on a port read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             refLatch <= '0;
    else if (portRdStrobe) refLatch <= pinSync;
  end
  assign pinDiff = (pinSync ^ refLatch) & portChgMask;

  always_comb begin
    strobe.wrEn     = regWrEn;
    strobe.timerSet = timerRoll;
    strobe.extSet   = extRise;
    strobe.portSet  = |pinDiff;
  end
endmodule

// File: rtl/irq_ctrl_dp.sv
module irq_ctrl_dp
  import irq_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  logic [REG_W-1:0] wrData,
  input  logic             periphReq,
  output logic [REG_W-1:0] regQ,
  output logic             irqOut
);
  logic [REG_W-1:0] regD;
  logic             srcTimer;
  logic             srcExt;
  logic             srcPort;
  logic             srcPeriph;

  always_comb begin
    regD = strobe.wrEn ? wrData : regQ;
    // A hardware set overrides a write of 0 in the same cycle
    if (strobe.timerSet) regD[BIT_TF] = 1'b1;
    if (strobe.extSet)   regD[BIT_XF] = 1'b1;
    if (strobe.portSet)  regD[BIT_PF] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regQ <= '0;
    else       regQ <= regD;
  end

  assign srcTimer  = regQ[BIT_TIE]  & regQ[BIT_TF];
  assign srcExt    = regQ[BIT_XIE]  & regQ[BIT_XF];
  assign srcPort   = regQ[BIT_PIE]  & regQ[BIT_PF];
  assign srcPeriph = regQ[BIT_PEIE] & periphReq;
  assign irqOut    = regQ[BIT_GIE] & (srcTimer | srcExt | srcPort | srcPeriph);
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
  import irq_ctrl_pkg::*;
#(
  parameter int PINS        = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            regWrEn,
  input  logic [7:0]      regWrData,
  output logic [7:0]      regRdData,
  input  logic            timerRoll,
  input  logic            extPin,
  input  logic            periphReq,
  input  logic [PINS-1:0] portPins,
  input  logic [PINS-1:0] portChgMask,
  input  logic            portRdStrobe,
  output logic [PINS-1:0] portRdData,
  output logic            irqOut
);
  ctlStrobe_t strobe;

  irq_ctrl_ctl #(.PINS(PINS), .SYNC_STAGES(SYNC_STAGES)) ctl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .timerRoll(timerRoll),
    .extPin(extPin), .portPins(portPins), .portChgMask(portChgMask),
    .portRdStrobe(portRdStrobe), .pinSync(portRdData), .strobe(strobe)
  );

  irq_ctrl_dp dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(regWrData),
    .periphReq(periphReq), .regQ(regRdData), .irqOut(irqOut)
  );
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       regWrEn,
  input logic [7:0] regWrData,
  input logic [7:0] regRdData,
  input logic       timerRoll,
  input logic       irqOut
);
  // R1: cleared while in reset
  always_comb begin
    if (!rstN) begin
      p_reset_zero_r1: assert (regRdData == 8'h00 && !irqOut);
    end
  end

  // R2: write stores the enable bits
  p_write_store_r2: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> regRdData[7:3] == $past(regWrData[7:3]));

  // R3: timer pulse sets its flag
  p_timer_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    timerRoll |=> regRdData[2]);

  // R7: flags never drop without a write
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> ((regRdData[2:0] & $past(regRdData[2:0])) == $past(regRdData[2:0])));

  // R8: hardware set wins over a clearing write
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regWrData[2] && timerRoll) |=> regRdData[2]);

  // R9: enabled timer flag under global enable raises the request
  p_timer_irq_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[7] && regRdData[5] && regRdData[2]) |-> irqOut);

  // R10: global enable masks everything
  p_global_mask_r10: assert property (@(posedge clk) disable iff (!rstN)
    !regRdData[7] |-> !irqOut);
endmodule

bind irq_ctrl_reg irq_ctrl_chk chk_i (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
  .regRdData(regRdData), .timerRoll(timerRoll), .irqOut(irqOut)
);

// File: tb/irq_ctrl_reg_tb_top.sv
module irq_ctrl_reg_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int         req;
    logic [7:0] expReg;
    logic       expIrq;
    bit         chkPort;
    logic [5:0] expPort;
  } item_t;

  logic       clk = 1'b0;
  logic       rstN;
  logic       regWrEn;
  logic [7:0] regWrData;
  logic [7:0] regRdData;
  logic       timerRoll;
  logic       extPin;
  logic       periphReq;
  logic [5:0] portPins;
  logic [5:0] portChgMask;
  logic       portRdStrobe;
  logic [5:0] portRdData;
  logic       irqOut;

  item_t scoreQ[$];
  int    nChecks = 0;
  int    nFails  = 0;
  bit    finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ctrl_reg dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .timerRoll(timerRoll), .extPin(extPin),
    .periphReq(periphReq), .portPins(portPins), .portChgMask(portChgMask),
    .portRdStrobe(portRdStrobe), .portRdData(portRdData), .irqOut(irqOut)
  );

  // Monitor: compares queued expectations shortly after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (scoreQ.size() > 0) begin
        item_t it;
        it = scoreQ.pop_front();
        nChecks++;
        if (regRdData !== it.expReg || irqOut !== it.expIrq ||
            (it.chkPort && portRdData !== it.expPort)) begin
          nFails++;
          $display("FAIL R%0d: reg=%h irq=%b port=%b expected reg=%h irq=%b port=%b",
                   it.req, regRdData, irqOut, portRdData,
                   it.expReg, it.expIrq, it.expPort);
        end
      end
    end
  end

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_state(input int req, input logic [7:0] r, input logic irq);
    item_t it;
    it.req = req; it.expReg = r; it.expIrq = irq; it.chkPort = 1'b0; it.expPort = '0;
    scoreQ.push_back(it);
  endtask

  task automatic expect_port(input int req, input logic [7:0] r, input logic irq,
                             input logic [5:0] p);
    item_t it;
    it.req = req; it.expReg = r; it.expIrq = irq; it.chkPort = 1'b1; it.expPort = p;
    scoreQ.push_back(it);
  endtask

  task automatic wr(input logic [7:0] d);
    regWrEn = 1'b1; regWrData = d;
    cyc();
    regWrEn = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
    end
  end

  initial begin
    rstN = 1'b0; regWrEn = 1'b0; regWrData = '0; timerRoll = 1'b0; extPin = 1'b0;
    periphReq = 1'b0; portPins = '0; portChgMask = '0; portRdStrobe = 1'b0;
    cyc(2);
    expect_state(1, 8'h00, 1'b0);                 // R1 during reset
    rstN = 1'b1;
    cyc();
    expect_state(1, 8'h00, 1'b0);                 // R1 after release

    wr(8'hF8); expect_state(2, 8'hF8, 1'b0);      // R2 enables stored
    wr(8'h00); expect_state(2, 8'h00, 1'b0);      // R2

    timerRoll = 1'b1; cyc(); timerRoll = 1'b0;
    expect_state(3, 8'h04, 1'b0);                 // R3 set with enables off

    wr(8'h20); expect_state(7, 8'h20, 1'b0);      // R7 write 0 clears
    wr(8'h24); expect_state(10, 8'h24, 1'b0);     // R10 GIE off masks
    wr(8'hA4); expect_state(9, 8'hA4, 1'b1);      // R9 timer request
    wr(8'hA0); expect_state(7, 8'hA0, 1'b0);      // R7

    regWrEn = 1'b1; regWrData = 8'hA0; timerRoll = 1'b1;
    cyc(); regWrEn = 1'b0; timerRoll = 1'b0;
    expect_state(8, 8'hA4, 1'b1);                 // R8 set beats clear
    wr(8'h00);

    extPin = 1'b1;
    cyc(); expect_state(4, 8'h00, 1'b0);          // R4 first stage
    cyc(); expect_state(4, 8'h00, 1'b0);          // R4 second stage
    cyc(); expect_state(4, 8'h02, 1'b0);          // R4 flag at third edge
    wr(8'h00); cyc(3); expect_state(4, 8'h00, 1'b0); // R4 held level no retrigger
    extPin = 1'b0;
    cyc(4); expect_state(4, 8'h00, 1'b0);         // R4 falling edge ignored

    wr(8'h90); expect_state(9, 8'h90, 1'b0);      // R9
    extPin = 1'b1; cyc(3);
    expect_state(9, 8'h92, 1'b1);                 // R9 external request
    wr(8'h00); extPin = 1'b0; cyc(3);

    portPins = 6'b000001; cyc(4);
    expect_port(5, 8'h00, 1'b0, 6'b000001);       // R5 masked-off pin ignored
    portChgMask = 6'b000001; cyc();
    expect_state(5, 8'h01, 1'b0);                 // R5 enabled pin sets flag
    wr(8'h00); expect_state(6, 8'h01, 1'b0);      // R6 mismatch re-sets
    portRdStrobe = 1'b1; cyc(); portRdStrobe = 1'b0;
    wr(8'h00); expect_state(6, 8'h00, 1'b0);      // R6 cleared after port read
    cyc(2); expect_state(6, 8'h00, 1'b0);         // R6 stays clear

    wr(8'h88);
    portPins = 6'b000011; cyc(4);
    expect_state(5, 8'h88, 1'b0);                 // R5 unmasked pin1 ignored
    portPins = 6'b000010; cyc(3);
    expect_port(9, 8'h89, 1'b1, 6'b000010);       // R9 port request
    portRdStrobe = 1'b1; cyc(); portRdStrobe = 1'b0;
    wr(8'h88); expect_state(7, 8'h88, 1'b0);      // R7 cleared by write

    wr(8'h80); periphReq = 1'b1; cyc();
    expect_state(10, 8'h80, 1'b0);                // R10 PEIE off masks peripheral
    wr(8'hC0); expect_state(9, 8'hC0, 1'b1);      // R9 peripheral request
    wr(8'h40); expect_state(10, 8'h40, 1'b0);     // R10 GIE off
    periphReq = 1'b0; wr(8'h00);

    timerRoll = 1'b1; cyc(); timerRoll = 1'b0;
    cyc(5); expect_state(7, 8'h04, 1'b0);         // R7 flag persists
    wr(8'h00); expect_state(7, 8'h00, 1'b0);      // R7

    cyc(2);
    finished = 1'b1;
    summary();
  end
endmodule